// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls an eight-pin general-purpose I/O port from a small register bus. Each pin has its own output latch, direction, analog-select, pull-up, input-threshold, slew-limit and open-drain bit. From these bits and the pad inputs the block produces per-pin pad controls: output enable, output data, pull-up enable, slew limit and threshold select. A per-pin override lets another peripheral drive the pad's data and enable in place of the latch. The pin stays readable while the override is active.

The pad inputs pass through a two-flop synchronizer. Each synchronized level is then gated by the pin's analog-select bit. Software reads the gated level at one address and the stored drive values at another. A write to either address loads the latch, so a read-modify-write on the latch never copies input levels into the drive values. Edge detection runs on the gated level. It sets sticky per-pin flags on rising edges, falling edges or both. The flags feed an interrupt output and a wake output.

The asynchronous active-low reset is released through a two-flop synchronizer, so the registers leave reset on the second clock edge after `rst_n` rises.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Reading address 0 returns, per pin, the synchronized pad level after analog gating, independent of the latch contents.
- R2: A write strobe at address 0 or at address 1 loads the write data into the output latch on that clock edge. Reading address 1 returns the latch contents, never the pad levels.
- R3: When a pin's direction bit (address 2) is 1 and its override is inactive, its output enable is 0. When the direction bit is 0, the pin is driven from the latch.
- R4: When a pin's analog-select bit (address 3) is 1, the pin reads as 0 at address 0 and its pad transitions set no change flag.
- R5: When a driven pin has its open-drain bit (address 7) set to 1, the pin can only sink. A latch bit of 0 gives output enable 1 with output data 0. A latch bit of 1 gives output enable 0. When the open-drain bit is 0, output enable is 1 and the output data equals the latch bit.
- R6: While a pin's override input is 1, its pad output enable and data equal the peripheral's enable and data. Its level still reads at address 0.
- R7: A pin's flag (read at address 10, bit n for pin n) is set on a synchronized rising edge when its rise-enable bit (address 8) is 1, and on a falling edge when its fall-enable bit (address 9) is 1. The flag is readable after the third clock edge following the pad change.
- R8: Flags are sticky. Writing 1 to a bit of address 10 clears that flag and writing 0 leaves it unchanged. If an edge and a clear of the same flag fall on the same edge, the flag stays set.
- R9: The pull-up bits (address 4), threshold bits (address 5, 1 = Schmitt, 0 = TTL) and slew bits (address 6, 1 = limited) appear unchanged on the matching pad outputs and read back at their addresses.
- R10: The interrupt output is 1 exactly when some flag is set whose pin has a rise or fall enable at 1. The wake output is 1 whenever any flag is set.
- R11: After reset, the direction and analog-select registers read 8'hFF. All other registers and the unused addresses 11 to 15 read 0. All output enables, the interrupt and the wake output are 0.
- R12: A pad change becomes visible at address 0 after the second clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad output data per pin |
| pad_pu | output | 8 | Weak pull-up enable per pin |
| pad_slew | output | 8 | Slew-limit select per pin |
| pad_st | output | 8 | Threshold select per pin (1 Schmitt, 0 TTL) |
| periph_ovr | input | 8 | Peripheral takes over the pad per pin |
| periph_out | input | 8 | Peripheral output data |
| periph_oe | input | 8 | Peripheral output enable |
| irq | output | 1 | Interrupt: any enabled flag pending |
| wake | output | 1 | Any flag pending |

## Verification
The bench drives inputs and samples outputs on the falling clock edge. It uses a fixed latency for each result. Register writes and all pad controls derived from them are due at the falling edge right after the write's rising edge. Read data and the override path are combinational and are checked 1 ns after they are driven. A pad change shows at address 0 after exactly two rising edges, which the bench checks one edge early (still old) and on time. A flag, and with it the interrupt and wake outputs, is due after the third rising edge. The same-cycle clear case places the clearing write on exactly that third edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] REG_PIN  = 4'd0;
  localparam logic [ADDR_W-1:0] REG_LAT  = 4'd1;
  localparam logic [ADDR_W-1:0] REG_DIR  = 4'd2;
  localparam logic [ADDR_W-1:0] REG_ANA  = 4'd3;
  localparam logic [ADDR_W-1:0] REG_PULL = 4'd4;
  localparam logic [ADDR_W-1:0] REG_LVL  = 4'd5;
  localparam logic [ADDR_W-1:0] REG_SLEW = 4'd6;
  localparam logic [ADDR_W-1:0] REG_ODR  = 4'd7;
  localparam logic [ADDR_W-1:0] REG_REN  = 4'd8;
  localparam logic [ADDR_W-1:0] REG_FEN  = 4'd9;
  localparam logic [ADDR_W-1:0] REG_FLG  = 4'd10;

  localparam int unsigned CFG_FIRST = 1;
  localparam int unsigned CFG_LAST  = 9;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_no = out_q;
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= q_nxt;
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN = 8,
  parameter int unsigned DW   = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIN-1:0]   pin_val,
  input  logic [NPIN-1:0]   flag_q,
  output logic [NPIN-1:0]   cfg_q [CFG_FIRST:CFG_LAST],
  output logic [NPIN-1:0]   flag_clr
);
  logic [CFG_LAST:CFG_FIRST] wr_en;
  logic [NPIN-1:0]           wr_val;

  assign wr_val = bus_wdata[NPIN-1:0];

  always_comb begin
    for (int r = CFG_FIRST; r <= CFG_LAST; r++) begin
      wr_en[r] = bus_we && (bus_addr == ADDR_W'(r));
    end
    wr_en[REG_LAT] = bus_we && (bus_addr == REG_LAT || bus_addr == REG_PIN);
  end

  for (genvar r = CFG_FIRST; r <= CFG_LAST; r++) begin : g_cfg
    localparam logic [NPIN-1:0] RV =
      (r == REG_DIR || r == REG_ANA) ? {NPIN{1'b1}} : {NPIN{1'b0}};
    gpio_cfg_reg #(.W(NPIN), .RST_VAL(RV)) u_reg (
      .clk    (clk),
      .rst_ni (rst_ni),
      .en     (wr_en[r]),
      .d      (wr_val),
      .q      (cfg_q[r])
    );
  end

  always_comb begin
    flag_clr = '0;
    if (bus_we && bus_addr == REG_FLG) flag_clr = wr_val;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == REG_PIN) bus_rdata[NPIN-1:0] = pin_val;
    if (bus_addr == REG_FLG) bus_rdata[NPIN-1:0] = flag_q;
    for (int r = CFG_FIRST; r <= CFG_LAST; r++) begin
      if (bus_addr == ADDR_W'(r)) bus_rdata[NPIN-1:0] = cfg_q[r];
    end
  end
endmodule

// File: rtl/gpio_in_edge.sv
module gpio_in_edge #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] ana_sel,
  output logic [NPIN-1:0] pin_val,
  output logic [NPIN-1:0] rise,
  output logic [NPIN-1:0] fall
);
  logic [NPIN-1:0] meta_q, sync_q, prev_q;
  logic [NPIN-1:0] meta_nxt, sync_nxt, prev_nxt;

  assign pin_val = sync_q & ~ana_sel;
  assign rise    = pin_val & ~prev_q;
  assign fall    = ~pin_val & prev_q;

  always_comb begin
    meta_nxt = pad_in;
    sync_nxt = meta_q;
    prev_nxt = pin_val;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_nxt;
      sync_q <= sync_nxt;
      prev_q <= prev_nxt;
    end
  end
endmodule

// File: rtl/gpio_ioc_flags.sv
module gpio_ioc_flags #(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] rise,
  input  logic [NPIN-1:0] fall,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] flag_q,
  output logic            irq,
  output logic            wake
);
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] flag_nxt;

  always_comb begin
    hit      = (rise & rise_en) | (fall & fall_en);
    flag_nxt = (flag_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_nxt;
  end

  assign irq  = |(flag_q & (rise_en | fall_en));
  assign wake = |flag_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned NPIN = 8
) (
  input  logic [NPIN-1:0] lat,
  input  logic [NPIN-1:0] dir_in,
  input  logic [NPIN-1:0] odr,
  input  logic [NPIN-1:0] ovr,
  input  logic [NPIN-1:0] p_out,
  input  logic [NPIN-1:0] p_oe,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_out
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_comb begin
      if (ovr[i]) begin
        pad_oe[i]  = p_oe[i];
        pad_out[i] = p_out[i];
      end else if (dir_in[i]) begin
        pad_oe[i]  = 1'b0;
        pad_out[i] = lat[i];
      end else if (odr[i]) begin
        pad_oe[i]  = ~lat[i];
        pad_out[i] = 1'b0;
      end else begin
        pad_oe[i]  = 1'b1;
        pad_out[i] = lat[i];
      end
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN = 8,
  parameter int unsigned DW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_we,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_slew,
  output logic [NPIN-1:0]   pad_st,
  input  logic [NPIN-1:0]   periph_ovr,
  input  logic [NPIN-1:0]   periph_out,
  input  logic [NPIN-1:0]   periph_oe,
  output logic              irq,
  output logic              wake
);
  logic            rst_sync_n;
  logic [NPIN-1:0] cfg_q [CFG_FIRST:CFG_LAST];
  logic [NPIN-1:0] lat_q, dir_q, ana_q, odr_q, ren_q, fen_q;
  logic [NPIN-1:0] pin_val, rise, fall, flag_q, flag_clr;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  gpio_regfile #(.NPIN(NPIN), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_val   (pin_val),
    .flag_q    (flag_q),
    .cfg_q     (cfg_q),
    .flag_clr  (flag_clr)
  );

  assign lat_q    = cfg_q[REG_LAT];
  assign dir_q    = cfg_q[REG_DIR];
  assign ana_q    = cfg_q[REG_ANA];
  assign odr_q    = cfg_q[REG_ODR];
  assign ren_q    = cfg_q[REG_REN];
  assign fen_q    = cfg_q[REG_FEN];
  assign pad_pu   = cfg_q[REG_PULL];
  assign pad_st   = cfg_q[REG_LVL];
  assign pad_slew = cfg_q[REG_SLEW];

  gpio_in_edge #(.NPIN(NPIN)) u_in (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .pad_in  (pad_in),
    .ana_sel (ana_q),
    .pin_val (pin_val),
    .rise    (rise),
    .fall    (fall)
  );

  gpio_ioc_flags #(.NPIN(NPIN)) u_ioc (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .rise    (rise),
    .fall    (fall),
    .rise_en (ren_q),
    .fall_en (fen_q),
    .clr     (flag_clr),
    .flag_q  (flag_q),
    .irq     (irq),
    .wake    (wake)
  );

  gpio_pad_mux #(.NPIN(NPIN)) u_mux (
    .lat     (lat_q),
    .dir_in  (dir_q),
    .odr     (odr_q),
    .ovr     (periph_ovr),
    .p_out   (periph_out),
    .p_oe    (periph_oe),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN = 8,
  parameter int unsigned DW   = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NPIN-1:0]   lat_q,
  input logic [NPIN-1:0]   dir_q,
  input logic [NPIN-1:0]   ana_q,
  input logic [NPIN-1:0]   odr_q,
  input logic [NPIN-1:0]   flag_q,
  input logic [NPIN-1:0]   periph_ovr,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_out,
  input logic              irq,
  input logic              wake
);
  logic [NPIN-1:0] clr_m;
  always_comb begin
    clr_m = '0;
    if (bus_we && bus_addr == REG_FLG) clr_m = bus_wdata[NPIN-1:0];
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && (bus_addr == REG_PIN || bus_addr == REG_LAT))
      |=> (lat_q == $past(bus_wdata[NPIN-1:0]))); // R2

  AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_ni)
    ((dir_q & ~periph_ovr & pad_oe) == '0)); // R3

  AST_ANALOG_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    ((flag_q & ~$past(flag_q) & $past(ana_q) & $past(ana_q, 2)) == '0)); // R4

  AST_OD_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_ni)
    ((odr_q & ~periph_ovr & pad_oe & pad_out) == '0)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (($past(flag_q) & ~$past(clr_m) & ~flag_q) == '0)); // R8

  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> wake); // R10
endmodule

bind gpio_port_ctrl gpio_port_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .lat_q      (lat_q),
  .dir_q      (dir_q),
  .ana_q      (ana_q),
  .odr_q      (odr_q),
  .flag_q     (flag_q),
  .periph_ovr (periph_ovr),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .irq        (irq),
  .wake       (wake)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_PIN = 4'd0, A_LAT = 4'd1, A_DIR = 4'd2, A_ANA = 4'd3,
                         A_PULL = 4'd4, A_LVL = 4'd5, A_SLEW = 4'd6, A_ODR = 4'd7,
                         A_REN = 4'd8, A_FEN = 4'd9, A_FLG = 4'd10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bus_we;
  logic [7:0] pad_in, pad_oe, pad_out, pad_pu, pad_slew, pad_st;
  logic [7:0] periph_ovr, periph_out, periph_oe;
  logic       irq, wake;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu), .pad_slew(pad_slew), .pad_st(pad_st),
    .periph_ovr(periph_ovr), .periph_out(periph_out), .periph_oe(periph_oe),
    .irq(irq), .wake(wake)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d, o, l, ov, pe, po, exp_oe;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    pad_in = '0; periph_ovr = '0; periph_out = '0; periph_oe = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R11 reset values at every address
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R11", $sformatf("reset read addr %0d", a), v,
            (a == 2 || a == 3) ? 8'hFF : 8'h00);
    end
    check("R11", "reset pad_oe", pad_oe, 8'h00);
    check("R11", "reset irq/wake", {6'd0, irq, wake}, 8'h00);

    // R1 R2: latch writes through both addresses, pin read independent
    wr(A_ANA, 8'h00);
    pad_in = 8'h3C;
    cyc(2);
    for (int k = 0; k < 16; k++) begin
      v = 8'(k * 29) ^ 8'h5A;
      wr((k % 2 == 1) ? A_PIN : A_LAT, v);
      rd(A_LAT, d);
      check("R2", "latch readback", d, v);
      rd(A_PIN, d);
      check("R1", "pin read", d, 8'h3C);
    end

    // R12 synchronizer latency
    pad_in = 8'hC3;
    cyc(1);
    rd(A_PIN, d);
    check("R12", "pin after one edge", d, 8'h3C);
    cyc(1);
    rd(A_PIN, d);
    check("R12", "pin after two edges", d, 8'hC3);

    // R3 R5: direction / open-drain / latch sweep
    for (int k = 0; k < 256; k++) begin
      o = 8'(k); l = ~8'(k) ^ 8'h33; v = 8'(k * 7);
      wr(A_ODR, o); wr(A_LAT, l); wr(A_DIR, v);
      check("R3", "input pins released", pad_oe & v, 8'h00);
      exp_oe = ~v & (~o | ~l);
      check("R5", "pad_oe", pad_oe, exp_oe);
      check("R5", "pad_out on driven pins", pad_out & pad_oe, l & ~o & exp_oe);
    end

    // R6 peripheral override
    wr(A_DIR, 8'h00); wr(A_ODR, 8'h00); wr(A_LAT, 8'hF0);
    for (int k = 0; k < 64; k++) begin
      ov = 8'(k * 37); pe = 8'(k * 91); po = 8'(k * 53);
      periph_ovr = ov; periph_oe = pe; periph_out = po;
      #1;
      exp_oe = (ov & pe) | ~ov;
      check("R6", "override pad_oe", pad_oe, exp_oe);
      check("R6", "override pad_out", pad_out & exp_oe, ((ov & po) | (~ov & 8'hF0)) & exp_oe);
    end
    periph_ovr = 8'hFF;
    rd(A_PIN, d);
    check("R6", "pin readable under override", d, 8'hC3);
    periph_ovr = 8'h00;

    // R9 pad pass-through
    for (int k = 0; k < 32; k++) begin
      v = 8'(k * 73 + 5);
      wr(A_PULL, v); wr(A_LVL, ~v); wr(A_SLEW, v ^ 8'h55);
      check("R9", "pull-up", pad_pu, v);
      check("R9", "threshold", pad_st, ~v);
      check("R9", "slew", pad_slew, v ^ 8'h55);
      rd(A_LVL, d);
      check("R9", "threshold readback", d, ~v);
    end

    // R7 R8: edge modes per pin
    pad_in = 8'h00;
    cyc(4);
    wr(A_FLG, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      for (int m = 1; m < 4; m++) begin
        wr(A_REN, (m % 2 == 1) ? 8'(1 << i) : 8'h00);
        wr(A_FEN, (m >= 2) ? 8'(1 << i) : 8'h00);
        pad_in = 8'(1 << i);
        cyc(3);
        rd(A_FLG, d);
        check("R7", $sformatf("rise pin %0d mode %0d", i, m), d,
              (m % 2 == 1) ? 8'(1 << i) : 8'h00);
        check("R10", "irq after rise", {7'd0, irq}, (m % 2 == 1) ? 8'h01 : 8'h00);
        wr(A_FLG, 8'hFF);
        pad_in = 8'h00;
        cyc(3);
        rd(A_FLG, d);
        check("R7", $sformatf("fall pin %0d mode %0d", i, m), d,
              (m >= 2) ? 8'(1 << i) : 8'h00);
        wr(A_FLG, 8'hFF);
        rd(A_FLG, d);
        check("R8", "flags cleared by write-one", d, 8'h00);
      end
    end

    // R4 analog gating blocks reads and flags
    wr(A_ANA, 8'h01); wr(A_REN, 8'hFF); wr(A_FEN, 8'hFF);
    pad_in = 8'h03;
    cyc(3);
    rd(A_PIN, d);
    check("R4", "analog pin reads 0", d, 8'h02);
    rd(A_FLG, d);
    check("R4", "analog pin no flag on rise", d, 8'h02);
    wr(A_FLG, 8'hFF);
    pad_in = 8'h00;
    cyc(3);
    rd(A_FLG, d);
    check("R4", "analog pin no flag on fall", d, 8'h02);
    wr(A_FLG, 8'hFF);
    wr(A_ANA, 8'h00);

    // R8 same-edge set wins over clear
    wr(A_REN, 8'h01); wr(A_FEN, 8'h00);
    pad_in = 8'h01;
    cyc(2);
    wr(A_FLG, 8'h01);
    rd(A_FLG, d);
    check("R8", "edge beats clear on same edge", d, 8'h01);
    wr(A_FLG, 8'h01);
    rd(A_FLG, d);
    check("R8", "later clear works", d, 8'h00);

    // R8 partial clear and stickiness, R10 irq/wake
    pad_in = 8'h00;
    cyc(3);
    wr(A_REN, 8'h03);
    pad_in = 8'h03;
    cyc(3);
    rd(A_FLG, d);
    check("R7", "two pins flagged", d, 8'h03);
    wr(A_FLG, 8'h01);
    cyc(5);
    rd(A_FLG, d);
    check("R8", "partial clear and sticky", d, 8'h02);
    check("R10", "irq and wake pending", {6'd0, irq, wake}, 8'h03);
    wr(A_REN, 8'h00);
    check("R10", "irq off with enables off, wake on", {6'd0, irq, wake}, 8'h01);
    wr(A_FLG, 8'hFF);
    check("R10", "wake off when no flag", {6'd0, irq, wake}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule